// File: doc/BRIEF.md
# Memory-Request Packet Target

This block is the receiving end of a packet stream of transaction-layer requests. Each packet arrives as a sequence of 32-bit double words (DWs), one per accepted cycle, on a valid/ready input stream that marks the first and last DW. The block reads the format and type bits of the first header DW. It services only two kinds of request, both with a 3-DW header and a 32-bit address: memory writes and memory reads. A write places its payload words into a small internal word-addressed memory. A read is answered with a completion-with-data packet on a valid/ready output stream. That packet carries the requested words and echoes the requester's identity and tag, so the response can be routed back and matched. Any other packet is consumed up to its last DW and has no effect.

Two state machines do the work. The receive machine has the states RX_HDR0, RX_HDR1, RX_HDR2, RX_DATA and RX_DRAIN:
- RX_HDR0 → RX_HDR1 on an accepted first DW of a supported request.
- RX_HDR0 → RX_DRAIN on an unsupported first DW.
- RX_HDR1 → RX_HDR2 on the second DW.
- RX_HDR2 → RX_DATA for a write. RX_HDR2 → RX_DRAIN for a read with trailing DWs.
- Any state → RX_HDR0 on an accepted last DW.

The completion machine has the states TX_IDLE, TX_HDR0, TX_HDR1, TX_HDR2 and TX_DATA:
- TX_IDLE → TX_HDR0 on a read request.
- TX_HDR0 → TX_HDR1 → TX_HDR2, one step per output handshake.
- TX_HDR2 → TX_DATA, or TX_HDR2 → TX_IDLE when the length is zero.
- TX_DATA → TX_IDLE on the handshake of the last data DW.

Input ready is withheld while a completion is in flight, so at most one read is outstanding.

Top module: `tlp_mem_target`

## Requirements
- R1: While reset is asserted and right after it, `in_ready` is 1 and `out_valid` is 0.
- R2: A request with DW0[30:29]=2'b10 and DW0[28:24]=5'b00000 is a write. It stores payload DW k at word index (DW2[31:2] + k) modulo the memory depth, for k = 0 to Length-1. Length is DW0[9:0], and addresses wrap past the top of the memory.
- R3: A request with DW0[30:29]=2'b00 and DW0[28:24]=5'b00000 is a read. It yields exactly one completion of 3+Length DWs. Its first DW has `out_sop`=1, bits [30:29]=2'b10, bits [28:24]=5'b01010 and bits [9:0] equal to the request Length. Only its last DW has `out_eop`=1.
- R4: Completion DW1 is {CPL_ID[15:0], status 3'b000, 1'b0, byte count = Length×4 in 12 bits}.
- R5: Completion DW2 is {requester ID = request DW1[31:16], tag = request DW1[15:8], 1'b0, lower address = {DW address[4:0], 2'b00}}.
- R6: Completion payload DW k holds the memory word at (read address + k) modulo the depth.
- R7: `in_ready` is 0 from the cycle after the read's third DW is accepted until the completion's last DW handshake, and `out_valid` is never 1 while `in_ready` is 1.
- R8: A packet with any other Fmt/Type pair is consumed up to `in_eop`. It produces no completion and leaves the memory unchanged.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data`, `out_sop` and `out_eop` hold in the next cycle.
- R10: Write payload DWs beyond Length are ignored, and a write with Length 0 stores nothing.
- R11: A read with Length 0 yields a 3-DW completion, with `out_eop` on DW2 and a byte count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input DW valid |
| in_ready | output | 1 | Block can accept an input DW |
| in_data | input | 32 | Input DW |
| in_sop | input | 1 | First DW of an input packet |
| in_eop | input | 1 | Last DW of an input packet |
| out_valid | output | 1 | Completion DW valid |
| out_ready | input | 1 | Downstream accepts the completion DW |
| out_data | output | 32 | Completion DW |
| out_sop | output | 1 | First DW of a completion |
| out_eop | output | 1 | Last DW of a completion |

## Verification
On every cycle, the assertions check four things: the reset values, the stability of the output stream under backpressure, the mutual exclusion of input ready and output valid, and the fixed fields of each completion header (format, type, status and byte count). Other behaviour can only be shown by the bench's scenarios, run against a reference memory model. That covers the data path of writes and reads, address wrap, the echo of requester ID and tag, the discarding of surplus or unsupported DWs, and zero-length requests.

// File: rtl/tlp_tgt_pkg.sv
package tlp_tgt_pkg;

    typedef enum logic [2:0] {
        RX_HDR0,
        RX_HDR1,
        RX_HDR2,
        RX_DATA,
        RX_DRAIN
    } rx_state_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_HDR0,
        TX_HDR1,
        TX_HDR2,
        TX_DATA
    } tx_state_t;

    localparam int DW_W   = 32;
    localparam int LEN_W  = 10;
    localparam int RID_W  = 16;
    localparam int TAG_W  = 8;

    localparam logic [1:0] FMT_HDR3_NODATA = 2'b00;
    localparam logic [1:0] FMT_HDR3_DATA   = 2'b10;
    localparam logic [4:0] TYPE_MEMREQ     = 5'b00000;
    localparam logic [4:0] TYPE_COMPL      = 5'b01010;
    localparam logic [2:0] STATUS_OK       = 3'b000;

endpackage

// File: rtl/tlp_word_mem.sv
module tlp_word_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/tlp_rx_parser.sv
module tlp_rx_parser
    import tlp_tgt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW_W-1:0]   in_data,
    input  logic              in_eop,
    input  logic              tx_busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW_W-1:0]   wr_data,
    output logic              rd_valid,
    output logic [RID_W-1:0]  rd_rid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LEN_W-1:0]  rd_len,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [4:0]        rd_lo
);
    rx_state_t         state_q, state_d;
    logic              is_wr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  remain_q;
    logic [RID_W-1:0]  rid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;
    logic              hdr_is_wr;
    logic              hdr_is_rd;

    assign accept    = in_valid && in_ready;
    assign hdr_is_wr = (in_data[30:29] == FMT_HDR3_DATA)   && (in_data[28:24] == TYPE_MEMREQ);
    assign hdr_is_rd = (in_data[30:29] == FMT_HDR3_NODATA) && (in_data[28:24] == TYPE_MEMREQ);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HDR0: begin
                if (accept) begin
                    if (in_eop)                      state_d = RX_HDR0;
                    else if (hdr_is_wr || hdr_is_rd) state_d = RX_HDR1;
                    else                             state_d = RX_DRAIN;
                end
            end
            RX_HDR1: begin
                if (accept) state_d = in_eop ? RX_HDR0 : RX_HDR2;
            end
            RX_HDR2: begin
                if (accept) begin
                    if (in_eop)      state_d = RX_HDR0;
                    else if (is_wr_q) state_d = RX_DATA;
                    else             state_d = RX_DRAIN;
                end
            end
            RX_DATA: begin
                if (accept && in_eop) state_d = RX_HDR0;
            end
            RX_DRAIN: begin
                if (accept && in_eop) state_d = RX_HDR0;
            end
            default: state_d = RX_HDR0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_HDR0;
        else        state_q <= state_d;
    end

    // header capture and write-address walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_wr_q  <= 1'b0;
            len_q    <= '0;
            remain_q <= '0;
            rid_q    <= '0;
            tag_q    <= '0;
            addr_q   <= '0;
        end else if (accept) begin
            unique case (state_q)
                RX_HDR0: begin
                    is_wr_q <= hdr_is_wr;
                    len_q   <= in_data[LEN_W-1:0];
                end
                RX_HDR1: begin
                    rid_q <= in_data[31:16];
                    tag_q <= in_data[15:8];
                end
                RX_HDR2: begin
                    addr_q   <= in_data[ADDR_W+1:2];
                    remain_q <= len_q;
                end
                RX_DATA: begin
                    if (remain_q != '0) begin
                        addr_q   <= addr_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready = !tx_busy;
        wr_en    = (state_q == RX_DATA) && accept && (remain_q != '0);
        wr_addr  = addr_q;
        wr_data  = in_data;
        rd_valid = (state_q == RX_HDR2) && accept && !is_wr_q;
        rd_rid   = rid_q;
        rd_tag   = tag_q;
        rd_len   = len_q;
        rd_addr  = in_data[ADDR_W+1:2];
        rd_lo    = in_data[6:2];
    end

endmodule

// File: rtl/tlp_cpl_gen.sv
module tlp_cpl_gen
    import tlp_tgt_pkg::*;
#(
    parameter int          ADDR_W = 6,
    parameter logic [15:0] CPL_ID = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [RID_W-1:0]  rd_rid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [4:0]        rd_lo,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DW_W-1:0]   mem_data,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW_W-1:0]   out_data,
    output logic              out_sop,
    output logic              out_eop
);
    localparam int BC_W = LEN_W + 2;

    tx_state_t         state_q, state_d;
    logic [RID_W-1:0]  rid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  remain_q;
    logic [ADDR_W-1:0] cur_q;
    logic [4:0]        lo_q;
    logic              step;
    logic [BC_W-1:0]   byte_cnt;

    assign step     = out_valid && out_ready;
    assign byte_cnt = {len_q, 2'b00};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (rd_valid) state_d = TX_HDR0;
            TX_HDR0: if (step) state_d = TX_HDR1;
            TX_HDR1: if (step) state_d = TX_HDR2;
            TX_HDR2: if (step) state_d = (len_q == '0) ? TX_IDLE : TX_DATA;
            TX_DATA: if (step && remain_q == LEN_W'(1)) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // request capture and read-address walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rid_q    <= '0;
            tag_q    <= '0;
            len_q    <= '0;
            remain_q <= '0;
            cur_q    <= '0;
            lo_q     <= '0;
        end else if (state_q == TX_IDLE && rd_valid) begin
            rid_q    <= rd_rid;
            tag_q    <= rd_tag;
            len_q    <= rd_len;
            remain_q <= rd_len;
            cur_q    <= rd_addr;
            lo_q     <= rd_lo;
        end else if (state_q == TX_DATA && step) begin
            cur_q    <= cur_q + 1'b1;
            remain_q <= remain_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != TX_IDLE);
        out_valid = (state_q != TX_IDLE);
        out_sop   = (state_q == TX_HDR0);
        out_eop   = ((state_q == TX_HDR2) && (len_q == '0)) ||
                    ((state_q == TX_DATA) && (remain_q == LEN_W'(1)));
        mem_addr  = cur_q;
        unique case (state_q)
            TX_HDR0: out_data = {1'b0, FMT_HDR3_DATA, TYPE_COMPL, 14'h0, len_q};
            TX_HDR1: out_data = {CPL_ID, STATUS_OK, 1'b0, byte_cnt};
            TX_HDR2: out_data = {rid_q, tag_q, 1'b0, lo_q, 2'b00};
            TX_DATA: out_data = mem_data;
            default: out_data = '0;
        endcase
    end

endmodule

// File: rtl/tlp_mem_target.sv
module tlp_mem_target
    import tlp_tgt_pkg::*;
#(
    parameter int          ADDR_W = 6,
    parameter logic [15:0] CPL_ID = 16'h0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_sop,
    output logic        out_eop
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DW_W-1:0]   wr_data;
    logic              rd_valid;
    logic [RID_W-1:0]  rd_rid;
    logic [TAG_W-1:0]  rd_tag;
    logic [LEN_W-1:0]  rd_len;
    logic [ADDR_W-1:0] rd_addr;
    logic [4:0]        rd_lo;
    logic [ADDR_W-1:0] mem_addr;
    logic [DW_W-1:0]   mem_data;
    logic              tx_busy;
    logic              sop_unused;

    // packet boundaries are tracked by the parser from the end marker alone
    assign sop_unused = in_sop;

    tlp_rx_parser #(.ADDR_W(ADDR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_eop   (in_eop),
        .tx_busy  (tx_busy),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_valid (rd_valid),
        .rd_rid   (rd_rid),
        .rd_tag   (rd_tag),
        .rd_len   (rd_len),
        .rd_addr  (rd_addr),
        .rd_lo    (rd_lo)
    );

    tlp_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DW_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (mem_addr),
        .rd_data (mem_data)
    );

    tlp_cpl_gen #(.ADDR_W(ADDR_W), .CPL_ID(CPL_ID)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_valid  (rd_valid),
        .rd_rid    (rd_rid),
        .rd_tag    (rd_tag),
        .rd_len    (rd_len),
        .rd_addr   (rd_addr),
        .rd_lo     (rd_lo),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .busy      (tx_busy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

endmodule

// File: rtl/tlp_mem_target_checker.sv
module tlp_mem_target_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_sop,
    input logic        out_eop
);
    logic [1:0] pos_q;
    logic [9:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            len_q <= '0;
        end else if (out_valid && out_ready) begin
            if (out_eop)            pos_q <= '0;
            else if (pos_q != 2'd3) pos_q <= pos_q + 2'd1;
            if (out_sop)            len_q <= out_data[9:0];
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid));

    assert_sop_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_data[30:24] == 7'b1001010 && !out_eop && pos_q == 2'd0));

    assert_status_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pos_q == 2'd1) |-> (out_data[15:13] == 3'b000 && out_data[11:0] == {len_q, 2'b00}));

    assert_zero_len_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pos_q == 2'd2 && len_q == 10'd0) |-> out_eop);

    assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

endmodule

bind tlp_mem_target tlp_mem_target_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/tlp_mem_target_tb.sv
module tlp_mem_target_tb;
    localparam int          ADDR_W = 6;
    localparam int          DEPTH  = 1 << ADDR_W;
    localparam logic [15:0] CPL_ID = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;

    int          n_checks = 0;
    int          n_fails  = 0;
    int          bp_mode  = 0;   // 0 random, 1 stall, 2 always ready
    int          pkts_done = 0;
    logic [31:0] rxq [$];
    logic        rx_eop [$];
    logic [31:0] mdl [DEPTH];
    bit          finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    tlp_mem_target #(.ADDR_W(ADDR_W), .CPL_ID(CPL_ID)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // output collector: decide out_ready, then record a word that will hand off
    initial begin
        forever begin
            @(negedge clk);
            if (bp_mode == 1)      out_ready = 1'b0;
            else if (bp_mode == 2) out_ready = 1'b1;
            else                   out_ready = ($urandom_range(0, 3) != 0);
            if (rst_n && out_valid && out_ready) begin
                rxq.push_back(out_data);
                rx_eop.push_back(out_eop);
                if (out_eop) pkts_done++;
            end
        end
    end

    task automatic send_dw(input logic [31:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        if (e) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        end
    endtask

    function automatic logic [31:0] dw0(input logic [1:0] fmt, input logic [4:0] typ, input logic [9:0] len);
        return {1'b0, fmt, typ, 14'($urandom), len};
    endfunction

    // write: npay payload DWs sent, len declared
    task automatic do_write(input logic [29:0] a, input int len, input int npay);
        logic [31:0] d;
        bit last_hdr;
        last_hdr = (npay == 0);
        send_dw(dw0(2'b10, 5'b00000, 10'(len)), 1'b1, 1'b0);
        send_dw($urandom, 1'b0, 1'b0);
        send_dw({a, 2'b00}, 1'b0, last_hdr);
        for (int k = 0; k < npay; k++) begin
            d = $urandom;
            if (k < len) mdl[(int'(a[ADDR_W-1:0]) + k) % DEPTH] = d;
            send_dw(d, 1'b0, k == npay - 1);
        end
    endtask

    task automatic start_read(input logic [29:0] a, input int len,
                              input logic [15:0] rid, input logic [7:0] tag);
        send_dw(dw0(2'b00, 5'b00000, 10'(len)), 1'b1, 1'b0);
        send_dw({rid, tag, 8'($urandom)}, 1'b0, 1'b0);
        send_dw({a, 2'b00}, 1'b0, 1'b1);
    endtask

    task automatic finish_read(input logic [29:0] a, input int len,
                               input logic [15:0] rid, input logic [7:0] tag, input int base);
        logic [31:0] e;
        while (pkts_done == base) @(negedge clk);
        check(32'(rxq.size()), 32'(3 + len), "R3 completion length");
        if (rxq.size() == 3 + len) begin
            check({1'b0, rxq[0][30:24], rxq[0][9:0]}, {1'b0, 7'b1001010, 10'(len)}, "R3 header DW0");
            e = {CPL_ID, 3'b000, 1'b0, 12'(len * 4)};
            check(rxq[1], e, len == 0 ? "R11 byte count" : "R4 header DW1");
            e = {rid, tag, 1'b0, a[4:0], 2'b00};
            check(rxq[2], e, "R5 header DW2");
            check(32'(rx_eop[2]), 32'(len == 0), len == 0 ? "R11 eop on DW2" : "R3 eop position");
            for (int k = 0; k < len; k++)
                check(rxq[3 + k], mdl[(int'(a[ADDR_W-1:0]) + k) % DEPTH], "R6 payload");
        end
        rxq.delete();
        rx_eop.delete();
    endtask

    task automatic do_read(input logic [29:0] a, input int len);
        logic [15:0] rid;
        logic [7:0]  tag;
        int base;
        rid = $urandom; tag = $urandom; base = pkts_done;
        start_read(a, len, rid, tag);
        finish_read(a, len, rid, tag, base);
    endtask

    task automatic do_junk(input logic [1:0] fmt, input logic [4:0] typ, input int ndw);
        send_dw(dw0(fmt, typ, 10'd2), 1'b1, ndw == 1);
        for (int k = 1; k < ndw; k++) send_dw($urandom, 1'b0, k == ndw - 1);
        repeat (8) @(negedge clk);
        check(32'(rxq.size()), 32'd0, "R8 no completion");
    endtask

    task automatic read_all();
        for (int b = 0; b < DEPTH; b += 8) do_read(30'(b) | (30'($urandom) << ADDR_W), 8);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] rid;
        logic [7:0]  tag;
        int base;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check({31'd0, in_ready}, 32'd1, "R1 in_ready in reset");
        check({31'd0, out_valid}, 32'd0, "R1 out_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check({31'd0, in_ready}, 32'd1, "R1 in_ready after reset");
        check({31'd0, out_valid}, 32'd0, "R1 out_valid after reset");

        // fill the whole memory with one long write (R2)
        do_write(30'h0, DEPTH, DEPTH);
        read_all();

        // wrap-around write and read (R2, R6)
        do_write(30'(DEPTH - 2), 5, 5);
        do_read(30'(DEPTH - 3), 7);

        // surplus payload ignored and zero-length write (R10)
        do_write(30'd10, 2, 5);
        do_write(30'd20, 0, 3);
        do_write(30'd21, 0, 0);
        do_read(30'd9, 14);

        // zero-length read (R11)
        do_read(30'd33, 0);

        // unsupported packets drained (R8)
        do_junk(2'b01, 5'b00000, 4);
        do_junk(2'b11, 5'b00000, 6);
        do_junk(2'b10, 5'b00010, 5);
        do_junk(2'b00, 5'b00100, 1);
        do_junk(2'b10, 5'b01010, 3);
        read_all();

        // input stalled while completion pending (R7)
        bp_mode = 1;
        rid = 16'hBEEF; tag = 8'h5A; base = pkts_done;
        start_read(30'd4, 2, rid, tag);
        repeat (4) @(negedge clk);
        check({31'd0, in_ready}, 32'd0, "R7 in_ready low during completion");
        check({31'd0, out_valid}, 32'd1, "R7 completion pending");
        check({31'd0, out_sop}, 32'd1, "R9 first DW held under stall");
        bp_mode = 0;
        finish_read(30'd4, 2, rid, tag, base);
        @(negedge clk);
        check({31'd0, in_ready}, 32'd1, "R7 in_ready back after completion");

        // constrained random mix
        for (int it = 0; it < 160; it++) begin
            int op;
            op = $urandom_range(0, 9);
            bp_mode = ($urandom_range(0, 3) == 0) ? 2 : 0;
            if (op < 4)
                do_write(30'($urandom), $urandom_range(0, 8), $urandom_range(0, 10));
            else if (op < 8)
                do_read(30'($urandom), $urandom_range(0, 9));
            else
                do_junk(2'($urandom_range(1, 3)), 5'($urandom_range(1, 31)), $urandom_range(1, 6));
        end
        bp_mode = 0;
        read_all();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule